// File: doc/BRIEF.md
# Hold-Gated SRAM Access Port

This block is the byte-wide static-memory face of a nonvolatile SRAM. It samples the active-low chip enable, output enable and write enable pins together with an active-low hold line, and sorts every clock cycle into a read, a write or an idle cycle. The shared data bus is split at the pad into an input byte, an output byte and an output-enable strobe. All pins are treated as synchronous to the block clock.

A write keeps the address and data from the last cycle spent in the write state. The byte is stored when chip enable or write enable rises and ends the write. A write that is cut short by the hold line or by the lockout stores nothing. Reads return the addressed byte one cycle after the address is sampled and track address changes with no control edge. Each completed write raises a one-cycle write-done pulse. Each completed read raises a one-cycle read-done pulse with the address that was read. These pulses feed a separate nonvolatile controller, and that controller's lockout input silences the port while a store or recall is running.

Top module: `nvsram_sram_port`

## Requirements
- R1: While reset is asserted, and until the internal reset synchroniser releases, `dq_oe`, `wr_done` and `rd_done` are 0.
- R2: A cycle with `ce_n`=0, `oe_n`=0, `we_n`=1, `hold_n`=1 and `nv_lock`=0 is a read. After the clock edge that samples it, `dq_oe` is 1 and `dq_out` holds the byte stored at `addr`.
- R3: During consecutive read cycles, `dq_out` follows each new address one cycle after it is sampled, with no control-pin transition.
- R4: After any sampled cycle in which `ce_n` or `oe_n` is 1, or `we_n` or `hold_n` is 0, `dq_oe` is 0. This includes a write entered with `oe_n` held low.
- R5: A cycle with `ce_n`=0, `we_n`=0, `hold_n`=1 and `nv_lock`=0 is a write. The byte stored is the `dq_in` value from the last write cycle, at that cycle's address. It is committed on the first following cycle in which `ce_n` or `we_n` is 1 while `hold_n`=1 and `nv_lock`=0.
- R6: A write whose write state ends because `hold_n` falls or `nv_lock` rises stores nothing and produces no `wr_done`.
- R7: While `nv_lock` is 1, read cycles leave `dq_oe` at 0 and write cycles leave the array unchanged.
- R8: `wr_done` is 1 for exactly the one cycle after the committing edge.
- R9: A read ends when the address changes during a read, or when the read state drops while `hold_n`=1 and `nv_lock`=0. On the edge that samples this, `rd_done` pulses for one cycle and `rd_addr` carries the full 15-bit address of the finished read. A read ended by `hold_n`=0 or `nv_lock`=1 gives no pulse.
- R10: `wr_done` and `rd_done` are never 1 in the same cycle.
- R11: The array holds 2^MEM_AW bytes (2048 by default) and is indexed by the low MEM_AW address bits. Addresses that agree in those bits share one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hold_n | input | 1 | Hold line from the nonvolatile side, active low; low blocks all access |
| nv_lock | input | 1 | Lockout from the nonvolatile controller, active high |
| addr | input | ADDR_W (15) | Byte address |
| dq_in | input | DATA_W (8) | Data bus input side |
| dq_out | output | DATA_W (8) | Data bus output side |
| dq_oe | output | 1 | Data bus output enable |
| wr_done | output | 1 | One-cycle pulse per committed write |
| rd_done | output | 1 | One-cycle pulse per completed read |
| rd_addr | output | ADDR_W (15) | Address of the read reported by `rd_done` |

## Verification
The bench ends writes in four ways: chip enable rising, write enable rising, the hold line falling, and the lockout rising. It then reads the byte back, so a design that commits on an abort leaves the wrong byte in memory. A design that latches the first write cycle instead of the last one is caught by multi-cycle writes whose data changes each cycle. Read bursts that repeat an address, change it every cycle, and end by each control pin check the read-done pulse. A design that reports repeated addresses, or reports a read that the hold line cut off, gets pulse checks wrong. Writes entered with output enable still low, aliased addresses, and locked reads check that the bus is released and that the array indexing is right.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

endpackage

// File: rtl/sram_port_rstsync.sv
module sram_port_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sram_port_wrcap.sv
module sram_port_wrcap
  import sram_port_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          cyc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          hold_n,
  input  logic          nv_lock,
  output logic          commit,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data,
  output logic          wr_done
);

  logic          held_q, held_d;
  logic [AW-1:0] haddr_q, haddr_d;
  logic [DW-1:0] hdata_q, hdata_d;
  logic          done_q, done_d;
  logic          in_write;

  // next state: track the newest write-state cycle, commit on a clean exit
  always_comb begin
    in_write = (cyc == CYC_WRITE);
    held_d   = in_write;
    haddr_d  = haddr_q;
    hdata_d  = hdata_q;
    if (in_write) begin
      haddr_d = addr;
      hdata_d = din;
    end
    commit = held_q && !in_write && hold_n && !nv_lock;
    done_d = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      haddr_q <= '0;
      hdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      held_q  <= held_d;
      haddr_q <= haddr_d;
      hdata_q <= hdata_d;
      done_q  <= done_d;
    end
  end

  assign cm_addr = haddr_q;
  assign cm_data = hdata_q;
  assign wr_done = done_q;

endmodule

// File: rtl/sram_port_rdtrack.sv
module sram_port_rdtrack
  import sram_port_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          cyc,
  input  logic [AW-1:0] addr,
  input  logic          hold_n,
  input  logic          nv_lock,
  output logic          rd_done,
  output logic [AW-1:0] rd_addr
);

  logic          live_q, live_d;
  logic [AW-1:0] taddr_q, taddr_d;
  logic          done_q, done_d;
  logic [AW-1:0] raddr_q, raddr_d;
  logic          in_read;
  logic          finish;

  always_comb begin
    in_read = (cyc == CYC_READ);
    finish  = live_q && (!in_read || (addr != taddr_q)) && hold_n && !nv_lock;
    live_d  = in_read;
    taddr_d = in_read ? addr : taddr_q;
    done_d  = finish;
    raddr_d = finish ? taddr_q : raddr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      taddr_q <= '0;
      done_q  <= 1'b0;
      raddr_q <= '0;
    end else begin
      live_q  <= live_d;
      taddr_q <= taddr_d;
      done_q  <= done_d;
      raddr_q <= raddr_d;
    end
  end

  assign rd_done = done_q;
  assign rd_addr = raddr_q;

endmodule

// File: rtl/sram_port_array.sv
module sram_port_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rdata_q <= mem[rd_addr];
    end
  end

  assign rd_data = rdata_q;

endmodule

// File: rtl/nvsram_sram_port.sv
module nvsram_sram_port
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hold_n,
  input  logic              nv_lock,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              wr_done,
  output logic              rd_done,
  output logic [ADDR_W-1:0] rd_addr
);

  logic              rst_sync_n;
  cyc_e              cyc;
  logic              commit;
  logic [MEM_AW-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;
  logic              oe_q, oe_d;
  logic              rd_cyc;

  sram_port_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // cycle decode: the hold line and the lockout qualify every access
  always_comb begin
    cyc = CYC_IDLE;
    if (!ce_n && hold_n && !nv_lock) begin
      if (!we_n) begin
        cyc = CYC_WRITE;
      end else if (!oe_n) begin
        cyc = CYC_READ;
      end
    end
    rd_cyc = (cyc == CYC_READ);
    oe_d   = rd_cyc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oe_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
    end
  end

  sram_port_wrcap #(.AW(MEM_AW), .DW(DATA_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cyc     (cyc),
    .addr    (addr[MEM_AW-1:0]),
    .din     (dq_in),
    .hold_n  (hold_n),
    .nv_lock (nv_lock),
    .commit  (commit),
    .cm_addr (cm_addr),
    .cm_data (cm_data),
    .wr_done (wr_done)
  );

  sram_port_rdtrack #(.AW(ADDR_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cyc     (cyc),
    .addr    (addr),
    .hold_n  (hold_n),
    .nv_lock (nv_lock),
    .rd_done (rd_done),
    .rd_addr (rd_addr)
  );

  sram_port_array #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (cm_addr),
    .wr_data (cm_data),
    .rd_en   (rd_cyc),
    .rd_addr (addr[MEM_AW-1:0]),
    .rd_data (dq_out)
  );

  assign dq_oe = oe_q;

endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic hold_n,
  input logic nv_lock,
  input logic dq_oe,
  input logic wr_done,
  input logic rd_done
);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && hold_n && !nv_lock) |=> dq_oe);

  a_r4_release_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || ce_n || oe_n || !hold_n) |=> !dq_oe);

  a_r7_lock_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    nv_lock |=> !dq_oe);

  a_r6_blocked_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n || nv_lock) |=> (!wr_done && !rd_done));

  a_r5_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(!ce_n && !we_n, 2));

  a_r8_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_done && rd_done));

endmodule

bind nvsram_sram_port sram_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .hold_n  (hold_n),
  .nv_lock (nv_lock),
  .dq_oe   (dq_oe),
  .wr_done (wr_done),
  .rd_done (rd_done)
);

// File: tb/tb_nvsram_sram_port.sv
module tb_nvsram_sram_port;

  localparam int AW  = 15;
  localparam int DW  = 8;
  localparam int MAW = 11;

  logic          clk;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, hold_n, nv_lock;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe, wr_done, rd_done;
  logic [AW-1:0] rd_addr;

  nvsram_sram_port #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hold_n(hold_n), .nv_lock(nv_lock), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_done(wr_done), .rd_done(rd_done),
    .rd_addr(rd_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  logic [DW-1:0] mdl [1<<MAW];
  bit            vld [1<<MAW];
  logic [AW-1:0] wl [16];
  int            wl_n = 0;

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=<150000", cyc_cnt);
      report();
    end
  end

  function automatic int idx(input logic [AW-1:0] a);
    return int'(a[MAW-1:0]);
  endfunction

  function automatic logic [DW-1:0] exp_byte(input logic [AW-1:0] a);
    return mdl[idx(a)];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of pins, wait for the sampling edge, settle past it
  task automatic pins(input logic c, input logic o, input logic w, input logic h,
                      input logic l, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = c; oe_n = o; we_n = w; hold_n = h; nv_lock = l; addr = a; dq_in = d;
    @(posedge clk);
    #1;
    check(!(wr_done && rd_done), "R10 exclusive", {wr_done, rd_done}, 0);
  endtask

  task automatic idle();
    pins(1, 1, 1, 1, 0, addr, 8'h00);
  endtask

  task automatic note_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mdl[idx(a)] = d;
    vld[idx(a)] = 1'b1;
    wl[wl_n % 16] = a;
    wl_n++;
  endtask

  function automatic logic [AW-1:0] pick();
    if (wl_n > 0 && ($urandom % 2) == 0) begin
      int k = (wl_n < 16) ? wl_n : 16;
      return wl[$urandom % k];
    end
    return AW'($urandom);
  endfunction

  // mode 0: end by ce_n, 1: end by we_n, 2: abort by hold_n, 3: abort by lock
  task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int len, input int mode);
    for (int i = 0; i < len; i++) begin
      pins(0, 1, 0, 1, 0, a, (i == len - 1) ? d : DW'($urandom));
      check(!dq_oe, "R4 no drive in write", dq_oe, 0);
      check(!wr_done, "R8 no early done", wr_done, 0);
    end
    case (mode)
      0: pins(1, 1, 1, 1, 0, a, DW'($urandom));
      1: pins(0, 1, 1, 1, 0, a, DW'($urandom));
      2: pins(0, 1, 0, 0, 0, a, DW'($urandom));
      default: pins(0, 1, 0, 1, 1, a, DW'($urandom));
    endcase
    if (mode < 2) begin
      check(wr_done, "R8 wr_done after end", wr_done, 1);
      note_write(a, d);
    end else begin
      check(!wr_done, "R6 aborted write no done", wr_done, 0);
    end
    idle();
    check(!wr_done, "R8 wr_done one cycle", wr_done, 0);
  endtask

  // end: 0 ce_n high, 1 oe_n high, 2 hold_n low
  task automatic rd_op(input int n, input int endk);
    logic [AW-1:0] prev = '0;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a = (i > 0 && ($urandom % 4) == 0) ? prev : pick();
      pins(0, 0, 1, 1, 0, a, DW'($urandom));
      check(dq_oe, "R2 read drives", dq_oe, 1);
      if (vld[idx(a)])
        check(dq_out == exp_byte(a), (i == 0) ? "R2 read data" : "R3 follow addr",
              dq_out, exp_byte(a));
      if (i == 0) begin
        check(!rd_done, "R9 no pulse on first read", rd_done, 0);
      end else if (prev != a) begin
        check(rd_done, "R9 pulse on addr change", rd_done, 1);
        check(rd_addr == prev, "R9 rd_addr", rd_addr, prev);
      end else begin
        check(!rd_done, "R9 no pulse same addr", rd_done, 0);
      end
      prev = a;
    end
    case (endk)
      0: pins(1, 0, 1, 1, 0, prev, 8'h00);
      1: pins(0, 1, 1, 1, 0, prev, 8'h00);
      default: pins(0, 0, 1, 0, 0, prev, 8'h00);
    endcase
    check(!dq_oe, "R4 release after read", dq_oe, 0);
    if (endk < 2) begin
      check(rd_done, "R9 pulse at read end", rd_done, 1);
      check(rd_addr == prev, "R9 rd_addr at end", rd_addr, prev);
    end else begin
      check(!rd_done, "R9 hold cut read no pulse", rd_done, 0);
    end
    idle();
  endtask

  task automatic locked_read(input logic [AW-1:0] a);
    pins(0, 0, 1, 1, 1, a, 8'h00);
    check(!dq_oe, "R7 locked read no drive", dq_oe, 0);
    check(!rd_done, "R7 locked read no pulse", rd_done, 0);
    idle();
    check(!rd_done, "R7 no pulse after lock", rd_done, 0);
  endtask

  task automatic locked_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    pins(0, 1, 0, 1, 1, a, d);
    pins(0, 1, 0, 1, 1, a, d);
    pins(1, 1, 1, 1, 0, a, d);
    check(!wr_done, "R7 locked write no done", wr_done, 0);
    idle();
  endtask

  // read with oe_n low, then fall into a write with oe_n still low
  task automatic glow_write(input logic [AW-1:0] ra, input logic [AW-1:0] a,
                            input logic [DW-1:0] d);
    pins(0, 0, 1, 1, 0, ra, 8'h00);
    check(dq_oe, "R2 read before write", dq_oe, 1);
    pins(0, 0, 0, 1, 0, a, d);
    check(!dq_oe, "R4 oe low write releases", dq_oe, 0);
    check(rd_done, "R9 pulse on we_n low", rd_done, 1);
    check(rd_addr == ra, "R9 rd_addr on we_n low", rd_addr, ra);
    pins(0, 0, 0, 1, 0, a, d);
    check(!dq_oe, "R4 still released", dq_oe, 0);
    pins(1, 0, 1, 1, 0, a, 8'h00);
    check(wr_done, "R5 glow write done", wr_done, 1);
    note_write(a, d);
    idle();
  endtask

  task automatic read_expect(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    pins(0, 0, 1, 1, 0, a, 8'h00);
    check(dq_out == d, req, dq_out, d);
    idle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < (1 << MAW); i++) vld[i] = 1'b0;
    rst_n = 1'b0;
    ce_n = 1; oe_n = 1; we_n = 1; hold_n = 1; nv_lock = 0; addr = '0; dq_in = '0;
    // R1: read pins during reset must not drive
    for (int i = 0; i < 3; i++) begin
      pins(0, 0, 1, 1, 0, 15'h0010, 8'h00);
      check(!dq_oe && !wr_done && !rd_done, "R1 reset outputs",
            {dq_oe, wr_done, rd_done}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    pins(1, 1, 1, 1, 0, '0, 8'h00);
    check(!dq_oe && !wr_done && !rd_done, "R1 sync release outputs",
          {dq_oe, wr_done, rd_done}, 0);
    idle(); idle();

    // directed: last write cycle wins (R5), both end styles
    begin
      logic [AW-1:0] a = 15'h0123;
      pins(0, 1, 0, 1, 0, a, 8'h11);
      pins(0, 1, 0, 1, 0, a, 8'h22);
      pins(0, 1, 0, 1, 0, a, 8'h5A);
      pins(1, 1, 1, 1, 0, a, 8'hFF);
      check(wr_done, "R5 commit on ce_n rise", wr_done, 1);
      note_write(a, 8'h5A);
      idle();
      read_expect(a, 8'h5A, "R5 last write cycle data");
      wr_op(15'h0200, 8'h3C, 2, 1);
      read_expect(15'h0200, 8'h3C, "R5 commit on we_n rise");
      // aborts leave the byte alone (R6)
      wr_op(a, 8'hA5, 2, 2);
      read_expect(a, 8'h5A, "R6 hold abort keeps data");
      wr_op(a, 8'hA6, 3, 3);
      read_expect(a, 8'h5A, "R6 lock abort keeps data");
      // lockout (R7)
      locked_write(a, 8'hC3);
      read_expect(a, 8'h5A, "R7 locked write ignored");
      locked_read(a);
      // aliasing on the low address bits (R11)
      wr_op(a | 15'h0800, 8'h77, 1, 0);
      read_expect(a, 8'h77, "R11 alias shares byte");
      pins(0, 0, 1, 1, 0, a | 15'h4800, 8'h00);
      pins(1, 1, 1, 1, 0, a, 8'h00);
      check(rd_addr == (a | 15'h4800), "R11 rd_addr keeps upper bits", rd_addr, a | 15'h4800);
      idle();
      glow_write(a, 15'h0321, 8'h9E);
      read_expect(15'h0321, 8'h9E, "R5 glow write data");
      rd_op(4, 0);
      rd_op(3, 2);
    end

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0, 1: wr_op(pick(), DW'($urandom), 1 + int'($urandom % 3), int'($urandom % 2));
        2:    rd_op(1 + int'($urandom % 4), int'($urandom % 3));
        3:    wr_op(pick(), DW'($urandom), 1 + int'($urandom % 3), 2 + int'($urandom % 2));
        4:    locked_read(pick());
        default: glow_write(pick(), pick(), DW'($urandom));
      endcase
    end
    rd_op(6, 1);
    report();
  end

endmodule